// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block is the control unit of a microcoded 16-bit processor. It holds a 64-word control store. Each word is 35 bits wide and is selected by a 6-bit micro-state register. Every clock the block takes the current word and does two things. It drives the 26 datapath control bits of that word. It also forms the address of the next word. The next address comes from three sequencing fields and a few status inputs: a memory-ready flag, a latched branch-enable flag and three instruction-register bits.

A word's sequencing fields are a 6-bit target, a 2-bit test selector and a dispatch flag. When the dispatch flag is set, the next state is the instruction opcode with two zero bits on top, which gives a 16-way jump. Otherwise the target is used as given, with at most one status bit OR-ed into one of its low bits. The test selector picks which status bit and which target bit. This lets a state loop on itself while memory is busy, or fork on a branch condition or an addressing-mode bit, without an adder or a second address field.

The block also computes the branch-enable flag from the condition codes and the instruction's condition mask, and latches it when the current word asks for it. It drives the register-file selects for the destination and the first source. The store is filled with a small test microprogram that is computed inside the design.

Top module: `useq_top`

## Requirements
- R1: While reset is held, and until the first clock after the synchronised reset is released, the micro-state is 18 (the fetch entry) and the branch-enable flag is 0.
- R2: A control word is laid out as bit 34 = dispatch flag, bits 33:32 = test selector, bits 31:26 = target, bits 25:0 = datapath controls. With the test selector at 00 and the dispatch flag clear, the next state equals the target, whatever the status inputs are.
- R3: With test selector 01, memory-ready is OR-ed into target bit 1. A state whose target points back at itself therefore holds for as many cycles as ready stays low.
- R4: With test selector 10, the latched branch-enable flag is OR-ed into target bit 2.
- R5: With test selector 11, instruction bit 11 is OR-ed into target bit 0.
- R6: With the dispatch flag set, the next state is {2'b00, ir[15:12]}. In the test program, opcodes 10 and 11 reach a handler at states 10 and 11, which both continue to state 40 and then to state 18.
- R7: The branch-enable flag is loaded with (ir[11]&N)|(ir[10]&Z)|(ir[9]&P) only in cycles where datapath control bit 0 is set. In all other cycles it keeps its value.
- R8: Control bit 1 selects the destination register 3'b111; otherwise the destination is ir[11:9]. Control bit 2 selects ir[8:6] as the first source; otherwise the first source is ir[11:9].
- R9: ctrl_out shows bits 25:0 of the word for the current state. In the test program, bits 25:20 of each word hold that word's own address.
- R10: In the test program, fetch runs 18 → 33. State 33 waits on ready (target 33) and then goes to 35. State 35 goes to 32, and state 32 dispatches and loads the branch-enable flag. The other words are: state 0 tests the branch (target 18), with the taken path running 22 → 18. State 1 sets the first-source select bit and goes to 18. State 4 tests the mode bit (target 20), and states 20 and 21 set the link select and go to 18. Every other word jumps to 18.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| mem_ready | input | 1 | Memory reports that the access is complete |
| ir | input | 16 | Instruction register contents |
| cc_n | input | 1 | Negative condition code |
| cc_z | input | 1 | Zero condition code |
| cc_p | input | 1 | Positive condition code |
| upc | output | 6 | Current micro-state |
| ctrl_out | output | 26 | Datapath control bits of the current word |
| ben | output | 1 | Latched branch-enable flag |
| dr_sel | output | 3 | Destination register select |
| sr1_sel | output | 3 | First-source register select |

## Verification
The bench runs a full fetch and dispatch for each instruction. It predicts every state from the requirements and compares the state, the control tag, both register selects and the branch flag on every cycle.

It holds ready low for several cycles in the wait state. A sequencer that OR-ed ready into the wrong bit, or ignored it, would leave that state too early or never stall. Ready is held high in every other state, so a design that applied the ready test outside selector 01 would land on a wrong state such as 34 instead of 32.

Branches are driven both taken and untaken, with different condition-code and mask pairs. A wrong BEN term, or a flag that is not latched at the dispatch state, would send the taken path to 18 or the untaken path to 22. Both mode-bit forks and both undefined opcodes are exercised, so a shifted opcode field or a misplaced mode bit shows up as a wrong dispatch target.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int ADDR_W = 6;
  localparam int CTRL_W = 26;
  localparam int OPC_W  = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef enum logic [1:0] {
    TST_NONE   = 2'b00,
    TST_READY  = 2'b01,
    TST_BRANCH = 2'b10,
    TST_MODE   = 2'b11
  } tst_e;

  typedef struct packed {
    logic              dispatch;
    tst_e              tst;
    logic [ADDR_W-1:0] target;
    logic [CTRL_W-1:0] ctrl;
  } uword_t;

  localparam int CB_LOAD_BEN = 0;
  localparam int CB_DR_LINK  = 1;
  localparam int CB_SR1_LOW  = 2;
  localparam int TAG_LSB     = 20;

  localparam logic [ADDR_W-1:0] ST_FETCH    = 6'd18;
  localparam logic [ADDR_W-1:0] ST_MEMWAIT  = 6'd33;
  localparam logic [ADDR_W-1:0] ST_IRLOAD   = 6'd35;
  localparam logic [ADDR_W-1:0] ST_DECODE   = 6'd32;
  localparam logic [ADDR_W-1:0] ST_BR_TAKEN = 6'd22;
  localparam logic [ADDR_W-1:0] ST_LINK     = 6'd20;
  localparam logic [ADDR_W-1:0] ST_TRAPOUT  = 6'd40;
endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  output uword_t        word
);
  localparam int NW = 1 << AW;

  function automatic uword_t make_word(input int idx);
    uword_t w;
    w          = '0;
    w.tst      = TST_NONE;
    w.target   = ST_FETCH;
    w.ctrl[TAG_LSB +: ADDR_W] = ADDR_W'(idx);
    case (idx)
      18: w.target = ST_MEMWAIT;
      33: begin w.tst = TST_READY; w.target = ST_MEMWAIT; end
      35: w.target = ST_DECODE;
      32: begin w.dispatch = 1'b1; w.target = '0; w.ctrl[CB_LOAD_BEN] = 1'b1; end
      0:  w.tst = TST_BRANCH;
      1:  w.ctrl[CB_SR1_LOW] = 1'b1;
      4:  begin w.tst = TST_MODE; w.target = ST_LINK; end
      20, 21: w.ctrl[CB_DR_LINK] = 1'b1;
      10, 11: w.target = ST_TRAPOUT;
      default: ;
    endcase
    return w;
  endfunction

  uword_t rom [NW];

  for (genvar gi = 0; gi < NW; gi++) begin : g_rom
    assign rom[gi] = make_word(gi);
  end

  assign word = rom[addr];
endmodule

// File: rtl/useq_ben.sv
module useq_ben (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [2:0] mask,
  input  logic       cc_n,
  input  logic       cc_z,
  input  logic       cc_p,
  output logic       ben_q
);
  logic ben_eval;
  logic ben_d;

  always_comb begin
    ben_eval = (mask[2] & cc_n) | (mask[1] & cc_z) | (mask[0] & cc_p);
    ben_d    = load ? ben_eval : ben_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ben_q <= 1'b0;
    else        ben_q <= ben_d;
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int OW = OPC_W
) (
  input  uword_t        cur,
  input  logic          mem_ready,
  input  logic          ben,
  input  logic          mode_bit,
  input  logic [OW-1:0] opcode,
  output logic [AW-1:0] nxt
);
  localparam int PAD = AW - OW;

  always_comb begin
    nxt = cur.target;
    if (cur.dispatch) begin
      nxt = {{PAD{1'b0}}, opcode};
    end else begin
      case (cur.tst)
        TST_READY:  nxt[1] = cur.target[1] | mem_ready;
        TST_BRANCH: nxt[2] = cur.target[2] | ben;
        TST_MODE:   nxt[0] = cur.target[0] | mode_bit;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_ready,
  input  logic [15:0]       ir,
  input  logic              cc_n,
  input  logic              cc_z,
  input  logic              cc_p,
  output logic [ADDR_W-1:0] upc,
  output logic [CTRL_W-1:0] ctrl_out,
  output logic              ben,
  output logic [2:0]        dr_sel,
  output logic [2:0]        sr1_sel
);
  logic              rs_meta;
  logic              rst_sync_n;
  logic [ADDR_W-1:0] upc_nxt;
  uword_t            cur;
  logic              unused_ir;

  assign unused_ir = ^ir[5:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rs_meta    <= 1'b1;
      rst_sync_n <= rs_meta;
    end
  end

  useq_store #(.AW(ADDR_W)) i_store (
    .addr (upc),
    .word (cur)
  );

  useq_ben i_ben (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (cur.ctrl[CB_LOAD_BEN]),
    .mask  (ir[11:9]),
    .cc_n  (cc_n),
    .cc_z  (cc_z),
    .cc_p  (cc_p),
    .ben_q (ben)
  );

  useq_next #(.AW(ADDR_W), .OW(OPC_W)) i_next (
    .cur       (cur),
    .mem_ready (mem_ready),
    .ben       (ben),
    .mode_bit  (ir[11]),
    .opcode    (ir[15:12]),
    .nxt       (upc_nxt)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) upc <= ST_FETCH;
    else             upc <= upc_nxt;
  end

  always_comb begin
    ctrl_out = cur.ctrl;
    dr_sel   = cur.ctrl[CB_DR_LINK] ? 3'b111 : ir[11:9];
    sr1_sel  = cur.ctrl[CB_SR1_LOW] ? ir[8:6] : ir[11:9];
  end
endmodule

// File: rtl/useq_checker.sv
module useq_checker (
  input logic        clk,
  input logic        rst_sync_n,
  input logic [5:0]  upc,
  input logic [15:0] ir,
  input logic        mem_ready,
  input logic        ben,
  input logic [25:0] ctrl_out,
  input logic [2:0]  dr_sel
);
  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    upc == 6'd18 |=> upc == 6'd33); // R10
  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upc == 6'd33 && !mem_ready) |=> upc == 6'd33); // R3
  AST_READY_GO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upc == 6'd33 && mem_ready) |=> upc == 6'd35); // R3
  AST_DISPATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    upc == 6'd32 |=> upc == {2'b00, $past(ir[15:12])}); // R6
  AST_BEN_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ctrl_out[0] |=> $stable(ben)); // R7
  AST_LINK_DEST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upc == 6'd20 || upc == 6'd21) |-> dr_sel == 3'b111); // R8
endmodule

bind useq_top useq_checker i_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .upc        (upc),
  .ir         (ir),
  .mem_ready  (mem_ready),
  .ben        (ben),
  .ctrl_out   (ctrl_out),
  .dr_sel     (dr_sel)
);

// File: tb/test_useq_top.sv
`timescale 1ns/1ps
module test_useq_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mem_ready;
  logic [15:0] ir;
  logic        cc_n, cc_z, cc_p;
  logic [5:0]  upc;
  logic [25:0] ctrl_out;
  logic        ben;
  logic [2:0]  dr_sel, sr1_sel;

  int checks = 0;
  int errors = 0;
  logic ben_exp = 1'b0;

  typedef struct {
    logic [5:0] st;
    logic [2:0] dr;
    logic [2:0] sr1;
    logic       bn;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  useq_top i_useq_top (
    .clk(clk), .rst_n(rst_n), .mem_ready(mem_ready), .ir(ir),
    .cc_n(cc_n), .cc_z(cc_z), .cc_p(cc_p), .upc(upc),
    .ctrl_out(ctrl_out), .ben(ben), .dr_sel(dr_sel), .sr1_sel(sr1_sel)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic rdy, input logic [5:0] nxt);
    exp_t e;
    mem_ready = rdy;
    e.st  = nxt;
    e.dr  = (nxt == 6'd20 || nxt == 6'd21) ? 3'b111 : ir[11:9];
    e.sr1 = (nxt == 6'd1) ? ir[8:6] : ir[11:9];
    e.bn  = ben_exp;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic run_instr(input logic [3:0] op, input logic [2:0] f119,
                           input logic [2:0] f86, input logic n, input logic z,
                           input logic p, input int stalls);
    ir = {op, f119, f86, 6'h15};
    cc_n = n; cc_z = z; cc_p = p;
    step(1'b1, 6'd33);                          // R2: ready ignored at 18
    for (int i = 0; i < stalls; i++) step(1'b0, 6'd33); // R3 stall
    step(1'b1, 6'd35);                          // R3 release
    step(1'b1, 6'd32);                          // R10 / R2
    ben_exp = (f119[2] & n) | (f119[1] & z) | (f119[0] & p); // R7
    step(1'b1, {2'b00, op});                    // R6
    case (op)
      4'd0: begin                               // R4
        if (ben_exp) begin step(1'b1, 6'd22); step(1'b1, 6'd18); end
        else step(1'b1, 6'd18);
      end
      4'd4: begin                               // R5
        step(1'b1, f119[2] ? 6'd21 : 6'd20);
        step(1'b1, 6'd18);
      end
      4'd10, 4'd11: begin step(1'b1, 6'd40); step(1'b1, 6'd18); end
      default: step(1'b1, 6'd18);
    endcase
  endtask

  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(upc == e.st, "R10", "state", upc, e.st);
        chk(ctrl_out[25:20] == upc, "R9", "ctrl tag", ctrl_out[25:20], upc);
        chk(dr_sel == e.dr, "R8", "dr_sel", dr_sel, e.dr);
        chk(sr1_sel == e.sr1, "R8", "sr1_sel", sr1_sel, e.sr1);
        chk(ben == e.bn, "R7", "ben", ben, e.bn);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mem_ready = 1'b1; ir = '0;
    cc_n = 1'b1; cc_z = 1'b1; cc_p = 1'b1;
    repeat (4) @(negedge clk);
    chk(upc == 6'd18, "R1", "reset state", upc, 18);
    chk(ben == 1'b0, "R1", "reset ben", ben, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(upc == 6'd18, "R1", "state after sync release", upc, 18);
    chk(ctrl_out[25:20] == 6'd18, "R9", "reset tag", ctrl_out[25:20], 18);
    run_instr(4'd1, 3'b101, 3'b010, 1'b0, 1'b0, 1'b0, 3); // ADD, R8
    run_instr(4'd0, 3'b010, 3'b000, 1'b0, 1'b1, 1'b0, 0); // BR taken, R4
    run_instr(4'd0, 3'b100, 3'b111, 1'b0, 1'b1, 1'b1, 2); // BR untaken, R4
    run_instr(4'd0, 3'b001, 3'b000, 1'b0, 1'b0, 1'b1, 5); // BR taken on P
    run_instr(4'd4, 3'b100, 3'b011, 1'b1, 1'b0, 1'b0, 1); // JSR mode 1, R5
    run_instr(4'd4, 3'b011, 3'b011, 1'b1, 1'b1, 1'b1, 0); // JSR mode 0, R5
    run_instr(4'd10, 3'b000, 3'b000, 1'b0, 1'b0, 1'b0, 1); // R6 illegal
    run_instr(4'd11, 3'b110, 3'b000, 1'b1, 1'b0, 1'b0, 4); // R6 illegal
    run_instr(4'd5, 3'b011, 3'b001, 1'b0, 1'b0, 1'b1, 0);  // R2 default
    run_instr(4'd0, 3'b110, 3'b000, 1'b0, 1'b0, 1'b1, 0);  // BR untaken
    repeat (2) @(negedge clk);
    chk(q.size() == 0, "R10", "scoreboard drained", q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule